// File: doc/BRIEF.md
# Shared Fault Line Controller

This block sits between a power sequencer and a shared fault pin. The pin is active low and open-drain, and several controllers can be wired onto the same line. When the sequencer reports an internal fault event, the block pulls the line low for a fixed number of clock cycles. A new event that arrives while the pulse is running starts the count again. While the undervoltage flag is set, the block holds the line low without a time limit, so the line is released only when the undervoltage condition clears.

The block also watches the sampled level of the line. A low that lasts long enough is reported to the sequencer as an external fault, so a pull-low from any controller on the wire shuts every controller down. Short lows are rejected as glitches. A low that the block causes itself is never reported. After the block stops driving, detection comes back only once the line has been seen high. A hold-done flag tells the sequencer that the block is no longer asserting anything and the line is high again, so initialisation may end.

Top module: `faultLineCtl`

## Requirements
- R1: After reset, lineDriveLow (1 = pull the line low) and extFault are 0, and holdDone is 1 while lineIn (1 = line high) is 1.
- R2: A faultEvent sampled high on a clock edge sets lineDriveLow from that edge on for exactly PULSE_CYCLES cycles. It then returns to 0 unless uvActive is set.
- R3: A faultEvent that arrives while a pulse is active restarts the width count, so the line stays driven for PULSE_CYCLES cycles after the last event.
- R4: While uvActive is 1, lineDriveLow is 1 in the same cycle, with no time limit. When uvActive falls, the drive follows it, unless a one-shot pulse is still running, which then ends on its own count.
- R5: With the block not driving, once lineIn has been sampled 0 on FILTER_CYCLES consecutive edges, extFault is 1 from the last of those edges. lineDriveLow stays 0 in that case. The first edge that samples lineIn at 1 clears extFault.
- R6: A low run shorter than FILTER_CYCLES samples leaves extFault at 0. Successive short runs do not add up.
- R7: No low is reported as extFault while the block drives the line. After the drive ends, detection is re-armed only on an edge that samples lineIn at 1 with no drive active.
- R8: holdDone is 1 exactly when no pulse is running, uvActive is 0 and lineIn is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| faultEvent | input | 1 | One-cycle internal fault event that starts or restarts the pulse |
| uvActive | input | 1 | Undervoltage flag; holds the line low while it is 1 |
| lineIn | input | 1 | Synchronously sampled line level, 1 = high |
| lineDriveLow | output | 1 | Open-drain pull-down enable, 1 = pull the line low |
| extFault | output | 1 | External pull-low detected after filtering |
| holdDone | output | 1 | No assertion is pending and the line is high |

## Verification
The assertions take for granted that lineIn is already synchronous to clk and that a faultEvent lasts one cycle. They also take for granted that FILTER_CYCLES is at least 2, so that a detection always follows at least two low samples. The bench builds lineIn itself as the wired-AND of the block's own drive and a modelled external pull. It changes faultEvent, uvActive and the external pull only on falling clock edges, and every faultEvent it sends lasts one cycle. That keeps every property's premise inside what the design can see.

// File: rtl/faultLinePkg.sv
package faultLinePkg;

  // Per-cycle commands from the control to the counter datapath.
  typedef struct packed {
    logic loadPulse;  // reload the pulse width counter
    logic stepPulse;  // count the pulse width down by one
    logic incLow;     // count one more low sample
    logic clearLow;   // restart the low-run counter
  } lineStrobes_t;

endpackage

// File: rtl/faultLineDp.sv
module faultLineDp
  import faultLinePkg::*;
#(
  parameter int PULSE_CYCLES  = 4000,
  parameter int FILTER_CYCLES = 50
) (
  input  logic         clk,
  input  logic         rstN,
  input  lineStrobes_t strobes,
  output logic         pulseBusy,
  output logic         lowFull
);

  localparam int PW = $clog2(PULSE_CYCLES + 1);
  localparam int LW = $clog2(FILTER_CYCLES + 1);
  localparam logic [PW-1:0] PULSE_LOAD = PW'(PULSE_CYCLES);
  localparam logic [LW-1:0] LOW_LAST   = LW'(FILTER_CYCLES - 1);

  logic [PW-1:0] pulseCnt;
  logic [LW-1:0] lowCnt;

  // Pulse width counter: a reload wins over the count-down.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseCnt <= '0;
    end else if (strobes.loadPulse) begin
      pulseCnt <= PULSE_LOAD;
    end else if (strobes.stepPulse) begin
      pulseCnt <= pulseCnt - 1'b1;
    end
  end

  // Consecutive low-sample counter for the glitch filter.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt <= '0;
    end else if (strobes.clearLow) begin
      lowCnt <= '0;
    end else if (strobes.incLow) begin
      lowCnt <= lowCnt + 1'b1;
    end
  end

  assign pulseBusy = (pulseCnt != '0);
  assign lowFull   = (lowCnt == LOW_LAST);

endmodule

// File: rtl/faultLineCtrl.sv
module faultLineCtrl
  import faultLinePkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         faultEvent,
  input  logic         uvActive,
  input  logic         lineIn,
  input  logic         pulseBusy,
  input  logic         lowFull,
  output lineStrobes_t strobes,
  output logic         lineDriveLow,
  output logic         extFault,
  output logic         holdDone
);

  logic armed;
  logic countLow;
  logic setExt;

  assign lineDriveLow = pulseBusy | uvActive;

  // A low sample counts only when armed, not self-driven and not yet reported.
  assign countLow = armed & ~lineDriveLow & ~lineIn & ~extFault;
  assign setExt   = countLow & lowFull;

  always_comb begin
    strobes           = '0;
    strobes.loadPulse = faultEvent;
    strobes.stepPulse = pulseBusy;
    strobes.incLow    = countLow & ~lowFull;
    strobes.clearLow  = ~countLow;
  end

  // Detection is disarmed by own drive and re-armed by a high sample.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed <= 1'b0;
    end else if (lineDriveLow) begin
      armed <= 1'b0;
    end else if (lineIn) begin
      armed <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extFault <= 1'b0;
    end else if (lineIn) begin
      extFault <= 1'b0;
    end else if (setExt) begin
      extFault <= 1'b1;
    end
  end

  assign holdDone = ~pulseBusy & ~uvActive & lineIn;

endmodule

// File: rtl/faultLineCtl.sv
module faultLineCtl
  import faultLinePkg::*;
#(
  parameter int PULSE_CYCLES  = 4000,
  parameter int FILTER_CYCLES = 50
) (
  input  logic clk,
  input  logic rstN,
  input  logic faultEvent,
  input  logic uvActive,
  input  logic lineIn,
  output logic lineDriveLow,
  output logic extFault,
  output logic holdDone
);

  lineStrobes_t strobes;
  logic         pulseBusy;
  logic         lowFull;

  faultLineCtrl uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .faultEvent   (faultEvent),
    .uvActive     (uvActive),
    .lineIn       (lineIn),
    .pulseBusy    (pulseBusy),
    .lowFull      (lowFull),
    .strobes      (strobes),
    .lineDriveLow (lineDriveLow),
    .extFault     (extFault),
    .holdDone     (holdDone)
  );

  faultLineDp #(
    .PULSE_CYCLES  (PULSE_CYCLES),
    .FILTER_CYCLES (FILTER_CYCLES)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .pulseBusy (pulseBusy),
    .lowFull   (lowFull)
  );

endmodule

// File: rtl/faultLineChk.sv
module faultLineChk (
  input logic clk,
  input logic rstN,
  input logic faultEvent,
  input logic uvActive,
  input logic lineIn,
  input logic lineDriveLow,
  input logic extFault,
  input logic holdDone
);

  // R2: an event is followed by drive on the next cycle.
  assert_pulse_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    faultEvent |=> lineDriveLow);

  // R3: the drive cannot end right after an event has restarted the count.
  assert_restart_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lineDriveLow) |-> !$past(faultEvent));

  // R4: undervoltage never lets initialisation finish.
  assert_uv_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    uvActive |-> !holdDone);

  // R5: a report comes from a sampled low while the block itself was not driving.
  assert_ext_source_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(extFault) |-> ($past(!lineIn) && $past(!lineDriveLow)));

  // R5: a high sample clears the report.
  assert_ext_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    lineIn |=> !extFault);

  // R6: a single low sample is never enough for a report.
  assert_filter_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(extFault) |-> $past(!lineIn, 2));

endmodule

bind faultLineCtl faultLineChk uChk (
  .clk          (clk),
  .rstN         (rstN),
  .faultEvent   (faultEvent),
  .uvActive     (uvActive),
  .lineIn       (lineIn),
  .lineDriveLow (lineDriveLow),
  .extFault     (extFault),
  .holdDone     (holdDone)
);

// File: tb/tb_faultLineCtl.sv
`timescale 1ns/1ps
module tb_faultLineCtl;

  localparam int P = 40;
  localparam int F = 5;

  typedef struct {
    int    cyc;
    string tag;
    int    d;
    int    e;
    int    h;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic faultEvent = 1'b0;
  logic uvActive = 1'b0;
  logic extPull = 1'b0;
  logic lineIn;
  logic lineDriveLow;
  logic extFault;
  logic holdDone;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  expItem_t q[$];

  // Wired-AND line: low when this block or another device pulls it.
  assign lineIn = !(lineDriveLow || extPull);

  always #10 clk = ~clk;  // 50 MHz

  always @(posedge clk) cyc <= cyc + 1;

  faultLineCtl #(.PULSE_CYCLES(P), .FILTER_CYCLES(F)) dut (
    .clk          (clk),
    .rstN         (rstN),
    .faultEvent   (faultEvent),
    .uvActive     (uvActive),
    .lineIn       (lineIn),
    .lineDriveLow (lineDriveLow),
    .extFault     (extFault),
    .holdDone     (holdDone)
  );

  // d, e, h: expected drive, extFault, holdDone; -1 = don't care.
  function automatic void expectAt(int c, string tag, int d, int e, int h);
    expItem_t it;
    it.cyc = c; it.tag = tag; it.d = d; it.e = e; it.h = h;
    q.push_back(it);
  endfunction

  function automatic void cmp(string tag, string name, int c, int act, int exp);
    if (exp < 0) return;
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s cyc=%0d actual=%0d expected=%0d", tag, name, c, act, exp);
    end
  endfunction

  // Monitor: compare every expectation due in this cycle, away from the edge.
  always @(negedge clk) begin
    #5;
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].cyc == cyc) begin
        cmp(q[i].tag, "lineDriveLow", cyc, int'(lineDriveLow), q[i].d);
        cmp(q[i].tag, "extFault", cyc, int'(extFault), q[i].e);
        cmp(q[i].tag, "holdDone", cyc, int'(holdDone), q[i].h);
        q.delete(i);
      end else if (q[i].cyc < cyc) begin
        checks++;
        errors++;
        $display("FAIL %s missed cyc=%0d actual=%0d expected=%0d", q[i].tag, q[i].cyc, cyc, q[i].cyc);
        q.delete(i);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    wait (q.size() == 0);
    step(3);
  endtask

  task automatic sendEvent();
    faultEvent = 1'b1;
    step(1);
    faultEvent = 1'b0;
  endtask

  initial begin
    int c;
    step(3);
    // R1: outputs quiet while reset is held.
    c = cyc;
    expectAt(c + 1, "R1", 0, 0, 1);
    step(2);
    rstN = 1'b1;
    c = cyc;
    expectAt(c + 1, "R1", 0, 0, 1);
    drain();

    // R2: single one-shot pulse of P cycles.
    c = cyc;
    expectAt(c, "R8", 0, 0, 1);
    expectAt(c + 1, "R2", 1, 0, 0);
    expectAt(c + P, "R2", 1, -1, 0);
    expectAt(c + P + 1, "R2", 0, 0, 1);
    sendEvent();
    drain();

    // R3: second event restarts the width.
    c = cyc;
    expectAt(c + P + 1, "R3", 1, 0, 0);
    expectAt(c + P + 10, "R3", 1, 0, 0);
    expectAt(c + P + 11, "R3", 0, 0, 1);
    sendEvent();
    step(9);
    sendEvent();
    drain();

    // R4: undervoltage hold lasts beyond the pulse width.
    c = cyc;
    expectAt(c, "R4", 1, 0, 0);
    expectAt(c + 99, "R4", 1, 0, 0);
    expectAt(c + 100, "R4", 0, 0, 1);
    uvActive = 1'b1;
    step(100);
    uvActive = 1'b0;
    drain();

    // R4: undervoltage outlasting a running pulse keeps the line low.
    c = cyc;
    expectAt(c + P + 5, "R4", 1, 0, 0);
    expectAt(c + P + 20, "R4", 0, 0, 1);
    sendEvent();
    step(1);
    uvActive = 1'b1;
    step(P + 18);
    uvActive = 1'b0;
    drain();

    // R5: external pull of 20 cycles is reported after F samples.
    c = cyc;
    expectAt(c, "R8", 0, 0, 0);
    expectAt(c + F - 1, "R5", 0, 0, 0);
    expectAt(c + F, "R5", 0, 1, 0);
    expectAt(c + 20, "R5", 0, 1, 1);
    expectAt(c + 21, "R5", 0, 0, 1);
    extPull = 1'b1;
    step(20);
    extPull = 1'b0;
    drain();

    // R6: two short glitches of F-1 samples are rejected.
    c = cyc;
    expectAt(c + F, "R6", 0, 0, 1);
    expectAt(c + F + 3, "R6", 0, 0, 1);
    expectAt(c + 10 + F + 1, "R6", 0, 0, 1);
    extPull = 1'b1;
    step(F - 1);
    extPull = 1'b0;
    step(11 - F);
    extPull = 1'b1;
    step(F - 1);
    extPull = 1'b0;
    drain();

    // R7: own drive, then a held low from elsewhere, is not reported until re-armed.
    c = cyc;
    expectAt(c + 20, "R7", 1, 0, 0);
    expectAt(c + P + 20, "R7", 0, 0, 0);
    expectAt(c + P + 35 + F - 1, "R7", 0, 0, 0);
    expectAt(c + P + 35 + F, "R7", 0, 1, 0);
    expectAt(c + P + 46, "R7", 0, 0, 1);
    sendEvent();
    step(P - 4);
    extPull = 1'b1;
    step(33);
    extPull = 1'b0;
    step(5);
    extPull = 1'b1;
    step(10);
    extPull = 1'b0;
    drain();

    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule